// File: doc/BRIEF.md
# Local Divided-Count Timer

This block is a 32-bit down-counting timer that sits beside a processor's local interrupt unit. Software programs a start value, a clock-divide code and a timer entry (vector, mask, reload mode) through a flat word-wide register port. A prescaler slows the bus clock by a power of two that the divide code selects. Each divided tick lowers the count. When the count runs out, the timer records an expiry and, if the entry is unmasked and the unit is hardware-enabled, raises an interrupt request that carries the entry's vector.

In reload mode the count restarts from the start value after each expiry. In one-shot mode it stops at zero. Expiries that are not yet taken are held in a small saturating counter, and each accepted delivery takes one away. Writing the start value restarts the period. A software-enable bit in a unit control word masks the timer entry when it is cleared.

Top module: `lct_timer`

## Requirements
- R1: After reset, the control word reads 0 and the divide code reads 0. The start value and the current count both read 0. The timer entry reads 0x0001_0000 (masked), and `irqReq` is low.
- R2: The divide exponent is ({code[3], code[1:0]} + 1) mod 8, and the divisor is 2 to that exponent. Code bit 2 has no effect. Code 0x0 gives divide-by-2, and code 0xB gives divide-by-1.
- R3: After a nonzero start value N is written, the first expiry lands exactly N × divisor bus clock edges after the write edge.
- R4: Address 0x390 reads the current count, which is the remaining bus cycles of the period divided by the divisor, rounded up. It reads N right after the write. Writes to 0x390 are ignored.
- R5: Writing the start value (0x380) cancels the running period, begins a new one from the write edge, and clears all pending expiries.
- R6: A start value of 0 leaves the timer idle. The current count reads 0, and no expiry ever occurs.
- R7: With the reload bit (entry bit 17) set, the count reloads the start value on expiry and keeps running.
- R8: With the reload bit clear, the count stops at 0 after one expiry, and no further expiry occurs.
- R9: `irqReq` is high only while pending expiries exist, the entry mask (bit 16) is clear and `hwEnable` is high. `irqVector` equals entry bits [7:0]. Masking does not discard pending expiries.
- R10: Pending expiries saturate at 2^PEND_W − 1. Each cycle with `irqReq` and `irqAck` both high removes one.
- R11: Writing 0 to control bit 8 (address 0x0F0) sets the entry mask and clears pending expiries. While that bit is 0, every write to the entry stores the mask as 1.
- R12: The entry (0x320) keeps the vector in [7:0], the mask in bit 16 and the reload bit in bit 17, and its other bits read 0. The divide code (0x3E0) reads back bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwEnable | input | 1 | Unit hardware enable; gates interrupt requests |
| regAddr | input | 12 | Register byte offset for reads and writes |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the addressed register (combinational) |
| irqAck | input | 1 | Consumer accepts the present request |
| irqReq | output | 1 | Timer interrupt request |
| irqVector | output | 8 | Vector of the requested interrupt |

## Verification
The bench uses the default parameters: a 32-bit count and a 2-bit pending counter. With PEND_W of 2, the saturation limit of three pending expiries is reached after only a few short reload periods, so the saturating and draining behaviour can be checked within a few dozen cycles. All eight exponent codes, including the wrap to divide-by-1 and the ignored bit 2, are covered with small start values so that each period is short enough to check at its exact edge.

// File: rtl/lct_pkg.sv
package lct_pkg;
  localparam logic [11:0] OFS_CTRL  = 12'h0F0;
  localparam logic [11:0] OFS_ENTRY = 12'h320;
  localparam logic [11:0] OFS_START = 12'h380;
  localparam logic [11:0] OFS_CUR   = 12'h390;
  localparam logic [11:0] OFS_DIV   = 12'h3E0;

  localparam int MAX_EXP = 7;
  localparam int PRE_W   = MAX_EXP;

  typedef struct packed {
    logic loadCount;
    logic clearPend;
    logic deliver;
  } ctlStrobe_t;

  function automatic logic [7:0] divMinusOne(input logic [3:0] code);
    logic [2:0] expo;
    expo = {code[3], code[1:0]} + 3'd1;
    return (8'd1 << expo) - 8'd1;
  endfunction
endpackage

// File: rtl/lct_ctrl.sv
module lct_ctrl
  import lct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwEnable,
  input  logic [11:0]       regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              irqAck,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVector,
  input  logic [DATA_W-1:0] curCount,
  input  logic              pendNonZero,
  output ctlStrobe_t        strobe,
  output logic [DATA_W-1:0] startValue,
  output logic              periodic,
  output logic [7:0]        divM1
);
  logic             swEn;
  logic             entMask;
  logic [VEC_W-1:0] entVec;
  logic [3:0]       divCode;

  logic wrCtrl, wrEntry, wrStart, wrDiv;
  assign wrCtrl  = wrEn && (regAddr == OFS_CTRL);
  assign wrEntry = wrEn && (regAddr == OFS_ENTRY);
  assign wrStart = wrEn && (regAddr == OFS_START);
  assign wrDiv   = wrEn && (regAddr == OFS_DIV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swEn       <= 1'b0;
      entMask    <= 1'b1;
      entVec     <= '0;
      periodic   <= 1'b0;
      startValue <= '0;
      divCode    <= '0;
    end else begin
      if (wrCtrl) begin
        swEn <= wrData[8];
        if (!wrData[8]) entMask <= 1'b1;
      end
      if (wrEntry) begin
        entVec   <= wrData[VEC_W-1:0];
        entMask  <= wrData[16] | ~swEn;
        periodic <= wrData[17];
      end
      if (wrStart) startValue <= wrData;
      if (wrDiv)   divCode    <= wrData[3:0];
    end
  end

  assign divM1     = divMinusOne(divCode);
  assign irqReq    = pendNonZero && !entMask && hwEnable;
  assign irqVector = entVec;

  always_comb begin
    strobe.loadCount = wrStart;
    strobe.clearPend = wrCtrl && !wrData[8];
    strobe.deliver   = irqReq && irqAck;
  end

  always_comb begin
    rdData = '0;
    case (regAddr)
      OFS_CTRL:  rdData[8] = swEn;
      OFS_ENTRY: begin
        rdData[VEC_W-1:0] = entVec;
        rdData[16]        = entMask;
        rdData[17]        = periodic;
      end
      OFS_START: rdData = startValue;
      OFS_CUR:   rdData = curCount;
      OFS_DIV:   rdData[3:0] = divCode;
      default:   rdData = '0;
    endcase
  end

  // R11
  sw_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !swEn |-> entMask);

  // R11
  forced_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEntry && !swEn) |=> entMask);
endmodule

// File: rtl/lct_datapath.sv
module lct_datapath
  import lct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PEND_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] loadValue,
  input  logic [DATA_W-1:0] startValue,
  input  logic              periodic,
  input  logic [7:0]        divM1,
  output logic [DATA_W-1:0] curCount,
  output logic              pendNonZero
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [PRE_W-1:0]  pre;
  logic [PEND_W-1:0] pendCnt;
  logic running, tick, expire;

  assign running = (curCount != '0);
  assign tick    = running && ({1'b0, pre} >= divM1);
  assign expire  = tick && (curCount == DATA_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCount <= '0;
      pre      <= '0;
    end else if (strobe.loadCount) begin
      curCount <= loadValue;
      pre      <= '0;
    end else if (running) begin
      if (tick) begin
        pre <= '0;
        if (expire) curCount <= periodic ? startValue : '0;
        else        curCount <= curCount - DATA_W'(1);
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.loadCount || strobe.clearPend) begin
      pendCnt <= '0;
    end else begin
      case ({expire, strobe.deliver})
        2'b10:   if (pendCnt != PEND_MAX) pendCnt <= pendCnt + PEND_W'(1);
        2'b01:   pendCnt <= pendCnt - PEND_W'(1);
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  assign pendNonZero = (pendCnt != '0);

  // R5
  load_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCount |=> (pendCnt == '0) && (curCount == $past(loadValue)));

  // R8
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !periodic && !strobe.loadCount) |=> curCount == '0);

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && periodic && !strobe.loadCount) |=> curCount == $past(startValue));

  // R10
  deliver_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.deliver && !expire && !strobe.loadCount && !strobe.clearPend)
      |=> pendCnt == $past(pendCnt) - PEND_W'(1));

  // R6
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curCount == '0 && !strobe.loadCount) |=> curCount == '0);
endmodule

// File: rtl/lct_timer.sv
module lct_timer
  import lct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8,
  parameter int PEND_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwEnable,
  input  logic [11:0]       regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              irqAck,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVector
);
  ctlStrobe_t        strobe;
  logic [DATA_W-1:0] curCount, startValue;
  logic              pendNonZero, periodic;
  logic [7:0]        divM1;

  lct_ctrl #(.DATA_W(DATA_W), .VEC_W(VEC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .hwEnable(hwEnable), .regAddr(regAddr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqAck(irqAck),
    .irqReq(irqReq), .irqVector(irqVector), .curCount(curCount),
    .pendNonZero(pendNonZero), .strobe(strobe), .startValue(startValue),
    .periodic(periodic), .divM1(divM1)
  );

  lct_datapath #(.DATA_W(DATA_W), .PEND_W(PEND_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadValue(wrData),
    .startValue(startValue), .periodic(periodic), .divM1(divM1),
    .curCount(curCount), .pendNonZero(pendNonZero)
  );
endmodule

// File: tb/lct_timer_tb_top.sv
module lct_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hwEnable = 1'b1;
  logic [11:0] regAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqAck = 1'b0;
  logic        irqReq;
  logic [7:0]  irqVector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lct_timer dut_i (
    .clk(clk), .rstN(rstN), .hwEnable(hwEnable), .regAddr(regAddr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqAck(irqAck),
    .irqReq(irqReq), .irqVector(irqVector)
  );

  // {code[3:0], start[7:0], divisor[7:0]}
  localparam logic [19:0] VECS [10] = '{
    {4'h0, 8'd3, 8'd2},  {4'h1, 8'd2, 8'd4},  {4'h2, 8'd2, 8'd8},
    {4'h3, 8'd1, 8'd16}, {4'h8, 8'd1, 8'd32}, {4'h9, 8'd1, 8'd64},
    {4'hA, 8'd1, 8'd128},{4'hB, 8'd5, 8'd1},  {4'h4, 8'd3, 8'd2},
    {4'hF, 8'd4, 8'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitEdges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin : stim
    logic [31:0] v;
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(1);
    // R1 reset state
    rd(12'h0F0, v); check("R1 ctrl", v, 32'h0);
    rd(12'h3E0, v); check("R1 div", v, 32'h0);
    rd(12'h380, v); check("R1 start", v, 32'h0);
    rd(12'h390, v); check("R1 cur", v, 32'h0);
    rd(12'h320, v); check("R1 entry", v, 32'h0001_0000);
    check("R1 irq", {31'b0, irqReq}, 32'h0);

    // R11 mask forced while software disabled
    wr(12'h320, 32'h0002_00AB);
    rd(12'h320, v); check("R11 forced mask", v, 32'h0003_00AB);

    // R12 field layout
    wr(12'h0F0, 32'h0000_0100);
    rd(12'h0F0, v); check("R12 ctrl", v, 32'h0000_0100);
    wr(12'h320, 32'hFFF0_FF41);
    rd(12'h320, v); check("R12 entry", v, 32'h0000_0041);
    wr(12'h3E0, 32'hFFFF_FFF6);
    rd(12'h3E0, v); check("R12 div", v, 32'h0000_0006);

    // R2/R3 table of divide codes, one-shot unmasked
    for (int i = 0; i < 10; i++) begin
      logic [3:0] code; logic [7:0] n, dv;
      {code, n, dv} = VECS[i];
      wr(12'h3E0, {28'b0, code});
      wr(12'h380, {24'b0, n});
      rd(12'h390, v); check("R4 cur after load", v, {24'b0, n});
      waitEdges(int'(n) * int'(dv) - 1);
      check("R3 no early expiry", {31'b0, irqReq}, 32'h0);
      waitEdges(1);
      check("R2 R3 expiry at N*D", {31'b0, irqReq}, 32'h1);
      check("R9 vector", {24'b0, irqVector}, 32'h41);
    end

    // R4 rounding up, divisor 2, N=5
    wr(12'h3E0, 32'h0);
    wr(12'h380, 32'd5);
    waitEdges(1);
    rd(12'h390, v); check("R4 cur k=1", v, 32'd5);
    waitEdges(2);
    rd(12'h390, v); check("R4 cur k=3", v, 32'd4);

    // R8 one-shot stops, no second expiry
    wr(12'h3E0, 32'hB);
    wr(12'h380, 32'd3);
    waitEdges(3);
    check("R8 expired", {31'b0, irqReq}, 32'h1);
    irqAck = 1'b1; waitEdges(1); irqAck = 1'b0;
    check("R10 ack drains", {31'b0, irqReq}, 32'h0);
    waitEdges(10);
    check("R8 no further expiry", {31'b0, irqReq}, 32'h0);
    rd(12'h390, v); check("R8 cur zero", v, 32'h0);

    // R5 restart and pending clear
    wr(12'h380, 32'd2);
    waitEdges(2);
    check("R5 pre", {31'b0, irqReq}, 32'h1);
    wr(12'h380, 32'd10);
    check("R5 pending cleared", {31'b0, irqReq}, 32'h0);
    waitEdges(6);
    wr(12'h380, 32'd10);
    waitEdges(9);
    check("R5 restarted no early", {31'b0, irqReq}, 32'h0);
    waitEdges(1);
    check("R5 restarted expiry", {31'b0, irqReq}, 32'h1);

    // R7 periodic reload
    wr(12'h320, 32'h0002_0041);
    wr(12'h380, 32'd4);
    waitEdges(4);
    check("R7 first expiry", {31'b0, irqReq}, 32'h1);
    rd(12'h390, v); check("R7 reloaded", v, 32'd4);

    // R10 saturation at 3
    wr(12'h380, 32'd2);
    waitEdges(7);
    wr(12'h320, 32'h0000_0041);
    waitEdges(6);
    rd(12'h390, v); check("R8 stopped after mode switch", v, 32'h0);
    irqAck = 1'b1;
    waitEdges(2);
    check("R10 after two acks", {31'b0, irqReq}, 32'h1);
    waitEdges(1);
    check("R10 saturated at three", {31'b0, irqReq}, 32'h0);
    irqAck = 1'b0;

    // R9 masking and hardware enable
    wr(12'h320, 32'h0001_0041);
    wr(12'h380, 32'd2);
    waitEdges(3);
    check("R9 masked", {31'b0, irqReq}, 32'h0);
    wr(12'h320, 32'h0000_0041);
    check("R9 unmasked keeps pending", {31'b0, irqReq}, 32'h1);
    hwEnable = 1'b0; #1;
    check("R9 hw disabled", {31'b0, irqReq}, 32'h0);
    hwEnable = 1'b1; #1;
    check("R9 hw enabled", {31'b0, irqReq}, 32'h1);

    // R11 software disable clears pending and masks
    wr(12'h0F0, 32'h0);
    check("R11 irq dropped", {31'b0, irqReq}, 32'h0);
    rd(12'h320, v); check("R11 masked", v, 32'h0001_0041);
    wr(12'h0F0, 32'h100);
    wr(12'h320, 32'h0000_0041);
    check("R11 pending gone", {31'b0, irqReq}, 32'h0);

    // R6 zero start value
    wr(12'h380, 32'd0);
    rd(12'h390, v); check("R6 cur zero", v, 32'h0);
    waitEdges(20);
    check("R6 no expiry", {31'b0, irqReq}, 32'h0);
    wr(12'h390, 32'h55);
    rd(12'h390, v); check("R4 write ignored", v, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule